// File: doc/BRIEF.md
# Data access trace reporter

This block watches the load/store completion interface of a processor core and turns every data access that finishes without an error into one trace record. Each record carries the start address, the byte count, the read/write direction and the data, packed low-lane first. Downstream trace logic collects the records through a valid/ready handshake. When that logic stalls, the block pushes back on the completion interface instead of losing records.

A misaligned access reaches the block as two bus portions: a first portion and then a second portion. The block holds the first portion internally. If the second portion starts at the byte right after the first, the two are joined into one record. If the second portion has wrapped around to address zero, or does not follow the first for any other reason, each portion is reported as its own record, first portion first. A select input chooses whether the traced stream is data or instruction accesses. With instruction tracing selected, this port produces nothing.

Top module: `dtr_trace_port`

## Requirements
- R1: After a synchronous reset, `trc_valid` is low, `cmp_ready` is high and no half-access is held.
- R2: With `trace_data_sel` high, an accepted whole access (`cmp_part` = 2'b00, or the unused code 2'b11) without error yields exactly one record on the following cycle. The record carries the access's address, byte count, `cmp_write` flag and data.
- R3: An access with an error produces no record. An error on either portion of a split access suppresses every record of that access.
- R4: A completion accepted while `trace_data_sel` is low produces no record and discards any held first portion.
- R5: An accepted first portion (`cmp_part` = 2'b01) produces no record. It is held until the next portion arrives, and a later first or whole access replaces or discards it.
- R6: A second portion (`cmp_part` = 2'b10) whose address equals the held first portion's address plus its byte count, and is not zero, yields one record. That record has the first portion's address and direction, the summed byte count, and data equal to the first portion's bytes in the low lanes with the second portion's bytes directly above them.
- R7: A second portion at address zero, or at any address that does not follow the held first portion, yields two records on consecutive handshakes: the held portion first, then the second portion.
- R8: A second portion that arrives with no first portion held is reported as a standalone record.
- R9: While `trc_valid` is high and `trc_ready` is low, the record on the trace outputs stays unchanged and valid.
- R10: Records leave in acceptance order and none is lost. `cmp_ready` is high exactly when at most DEPTH-2 records are waiting.
- R11: Data lanes at or above the record's byte count read as zero. Byte lane i is bits 8*i+7 down to 8*i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trace_data_sel | input | 1 | 1 selects data-access tracing; 0 selects instruction tracing (port silent) |
| cmp_valid | input | 1 | A completion is offered |
| cmp_ready | output | 1 | Completion accepted at the edge when high together with `cmp_valid` |
| cmp_part | input | 2 | 00 whole, 01 first portion, 10 second portion, 11 treated as whole |
| cmp_err | input | 1 | The completion ended with an error response |
| cmp_write | input | 1 | 1 for a store, 0 for a load |
| cmp_addr | input | 32 | Byte address of this completion or portion |
| cmp_bytes | input | 3 | Bytes carried by this completion or portion |
| cmp_data | input | 32 | Data, right-justified in the low lanes |
| trc_valid | output | 1 | A trace record is presented |
| trc_ready | input | 1 | The consumer takes the record at the edge |
| trc_addr | output | 32 | Record start address |
| trc_bytes | output | 3 | Record byte count |
| trc_write | output | 1 | Record direction |
| trc_data | output | 32 | Record data, low lane first |

## Verification
Several properties are checked on every cycle. An errored completion, an instruction-selected completion and a first portion never push a record. A stalled record stays stable. The queue never overflows its storage, and unused data lanes on the output stay zero. Other behaviour only the bench's scenarios can show, by comparing each cycle with a behavioural queue model. That covers the joining of contiguous halves and the two-record split at address zero or a gap. It also covers the standalone lone second portion, the dropping of both halves when one errs, and the exact cycle when backpressure lowers `cmp_ready`.

// File: rtl/dtr_pkg.sv
package dtr_pkg;

    localparam int unsigned DTR_AW    = 32;
    localparam int unsigned DTR_LANES = 4;
    localparam int unsigned DTR_DW    = 8 * DTR_LANES;

    typedef enum logic [1:0] {
        PART_WHOLE  = 2'b00,
        PART_FIRST  = 2'b01,
        PART_SECOND = 2'b10,
        PART_SPARE  = 2'b11
    } part_e;

    typedef struct packed {
        logic [DTR_AW-1:0] addr;
        logic [2:0]        nbytes;
        logic              write;
        logic [DTR_DW-1:0] data;
    } dtr_rec_t;

    // keep byte lane i only when i is below the byte count
    function automatic logic [DTR_DW-1:0] lane_mask(input logic [2:0] n);
        logic [DTR_DW-1:0] m;
        for (int i = 0; i < int'(DTR_LANES); i++) begin
            m[8*i +: 8] = (i < int'(n)) ? 8'hFF : 8'h00;
        end
        return m;
    endfunction

endpackage

// File: rtl/dtr_merge.sv
module dtr_merge
    import dtr_pkg::*;
(
    input  dtr_rec_t lead,
    input  dtr_rec_t tail,
    output dtr_rec_t joined,
    output logic     adjacent
);

    logic [DTR_AW-1:0] follow_addr;

    always_comb begin
        follow_addr     = lead.addr + DTR_AW'(lead.nbytes);
        // a tail that wrapped to zero is never joined
        adjacent        = (tail.addr == follow_addr) && (tail.addr != '0);
        joined.addr     = lead.addr;
        joined.nbytes   = lead.nbytes + tail.nbytes;
        joined.write    = lead.write;
        joined.data     = lead.data | (tail.data << {lead.nbytes, 3'b000});
    end

endmodule

// File: rtl/dtr_outq.sv
module dtr_outq
    import dtr_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic [1:0] push_n,
    input  dtr_rec_t push_a,
    input  dtr_rec_t push_b,
    input  logic     out_ready,
    output logic     out_valid,
    output dtr_rec_t out_rec,
    output logic     room2
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        dtr_rec_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]     rd;
        logic [PTR_W-1:0]     wr;
        logic [CNT_W-1:0]     cnt;
    } q_t;

    q_t st_d, st_q;
    logic             pop;
    logic [PTR_W-1:0] wr1;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    assign out_valid = (st_q.cnt != '0);
    assign out_rec   = st_q.mem[st_q.rd];
    assign room2     = (st_q.cnt <= CNT_W'(DEPTH - 2));
    assign pop       = out_valid && out_ready;
    assign wr1       = step(st_q.wr);

    always_comb begin
        st_d = st_q;
        if (pop) begin
            st_d.rd = step(st_q.rd);
        end
        if (push_n != 2'd0) begin
            st_d.mem[st_q.wr] = push_a;
            st_d.wr           = wr1;
        end
        if (push_n == 2'd2) begin
            st_d.mem[wr1] = push_b;
            st_d.wr       = step(wr1);
        end
        st_d.cnt = st_q.cnt + CNT_W'(push_n) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R10
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(st_q.cnt) <= int'(DEPTH));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push_n != 2'd0) |-> (int'(st_q.cnt) + int'(push_n) <= int'(DEPTH)));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_rec)));

endmodule

// File: rtl/dtr_trace_port.sv
module dtr_trace_port
    import dtr_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        trace_data_sel,
    input  logic        cmp_valid,
    output logic        cmp_ready,
    input  logic [1:0]  cmp_part,
    input  logic        cmp_err,
    input  logic        cmp_write,
    input  logic [31:0] cmp_addr,
    input  logic [2:0]  cmp_bytes,
    input  logic [31:0] cmp_data,
    output logic        trc_valid,
    input  logic        trc_ready,
    output logic [31:0] trc_addr,
    output logic [2:0]  trc_bytes,
    output logic        trc_write,
    output logic [31:0] trc_data
);

    typedef struct packed {
        logic     held;
        logic     drop;
        dtr_rec_t half;
    } pend_t;

    pend_t    st_d, st_q;
    dtr_rec_t in_rec;
    dtr_rec_t merged_rec;
    dtr_rec_t push_a, push_b;
    dtr_rec_t head;
    logic [1:0] push_n;
    logic     adjacent;
    logic     room2;
    logic     fire;
    part_e    part;

    assign part      = part_e'(cmp_part);
    assign cmp_ready = room2;
    assign fire      = cmp_valid && room2;

    always_comb begin
        in_rec.addr   = cmp_addr;
        in_rec.nbytes = cmp_bytes;
        in_rec.write  = cmp_write;
        in_rec.data   = cmp_data & lane_mask(cmp_bytes);
    end

    dtr_merge u_merge (
        .lead     (st_q.half),
        .tail     (in_rec),
        .joined   (merged_rec),
        .adjacent (adjacent)
    );

    always_comb begin
        st_d   = st_q;
        push_n = 2'd0;
        push_a = in_rec;
        push_b = in_rec;
        if (fire) begin
            if (!trace_data_sel) begin
                st_d.held = 1'b0;
            end else begin
                unique case (part)
                    PART_FIRST: begin
                        st_d.held = 1'b1;
                        st_d.drop = cmp_err;
                        st_d.half = in_rec;
                    end
                    PART_SECOND: begin
                        st_d.held = 1'b0;
                        if (st_q.held) begin
                            if (!st_q.drop && !cmp_err) begin
                                if (adjacent) begin
                                    push_n = 2'd1;
                                    push_a = merged_rec;
                                end else begin
                                    push_n = 2'd2;
                                    push_a = st_q.half;
                                    push_b = in_rec;
                                end
                            end
                        end else if (!cmp_err) begin
                            push_n = 2'd1;
                        end
                    end
                    default: begin
                        st_d.held = 1'b0;
                        if (!cmp_err) begin
                            push_n = 2'd1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    dtr_outq #(.DEPTH(DEPTH)) u_outq (
        .clk       (clk),
        .rst       (rst),
        .push_n    (push_n),
        .push_a    (push_a),
        .push_b    (push_b),
        .out_ready (trc_ready),
        .out_valid (trc_valid),
        .out_rec   (head),
        .room2     (room2)
    );

    assign trc_addr  = head.addr;
    assign trc_bytes = head.nbytes;
    assign trc_write = head.write;
    assign trc_data  = head.data;

    // R3
    err_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && cmp_err) |-> (push_n == 2'd0));

    // R4
    sel_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !trace_data_sel) |-> (push_n == 2'd0));

    // R5
    first_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && trace_data_sel && cmp_part == 2'b01) |=> (st_q.held && !trc_valid || trc_valid));

    // R5
    first_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && cmp_part == 2'b01) |-> (push_n == 2'd0));

    // R11
    lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
        trc_valid |-> ((trc_data & ~lane_mask(trc_bytes)) == '0));

endmodule

// File: tb/tb_dtr_trace_port.sv
module tb_dtr_trace_port;
    import dtr_pkg::*;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trace_data_sel = 1'b1;
    logic        cmp_valid = 1'b0;
    logic        cmp_ready;
    logic [1:0]  cmp_part = 2'b00;
    logic        cmp_err = 1'b0;
    logic        cmp_write = 1'b0;
    logic [31:0] cmp_addr = '0;
    logic [2:0]  cmp_bytes = 3'd4;
    logic [31:0] cmp_data = '0;
    logic        trc_valid;
    logic        trc_ready = 1'b1;
    logic [31:0] trc_addr;
    logic [2:0]  trc_bytes;
    logic        trc_write;
    logic [31:0] trc_data;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    bit    rand_rdy = 1'b0;
    string cur_req = "R1";

    dtr_rec_t mq[$];
    bit       m_held;
    bit       m_drop;
    dtr_rec_t m_half;

    always #10 clk = ~clk;

    dtr_trace_port #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .trace_data_sel(trace_data_sel),
        .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_part(cmp_part),
        .cmp_err(cmp_err), .cmp_write(cmp_write), .cmp_addr(cmp_addr),
        .cmp_bytes(cmp_bytes), .cmp_data(cmp_data), .trc_valid(trc_valid),
        .trc_ready(trc_ready), .trc_addr(trc_addr), .trc_bytes(trc_bytes),
        .trc_write(trc_write), .trc_data(trc_data)
    );

    function automatic logic [31:0] keep(input logic [31:0] d, input int b);
        if (b >= 4) return d;
        return d & ((32'h1 << (8 * b)) - 32'h1);
    endfunction

    function automatic dtr_rec_t mk(input logic [31:0] a, input int b,
                                    input logic w, input logic [31:0] d);
        dtr_rec_t r;
        r.addr = a; r.nbytes = 3'(b); r.write = w; r.data = keep(d, b);
        return r;
    endfunction

    task automatic chk(input bit ok, input string what,
                       input logic [67:0] act, input logic [67:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // behavioural reference: queue of expected records
    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            m_held = 1'b0;
            m_drop = 1'b0;
        end else begin
            bit       acc;
            dtr_rec_t cur;
            acc = cmp_valid && (mq.size() <= DEPTH - 2);
            if (mq.size() != 0 && trc_ready) void'(mq.pop_front());
            if (acc) begin
                cur = mk(cmp_addr, int'(cmp_bytes), cmp_write, cmp_data);
                if (!trace_data_sel) begin
                    m_held = 1'b0;
                end else if (cmp_part == 2'b01) begin
                    m_held = 1'b1; m_drop = cmp_err; m_half = cur;
                end else if (cmp_part == 2'b10) begin
                    if (m_held) begin
                        if (!m_drop && !cmp_err) begin
                            if (cmp_addr != 0 &&
                                cmp_addr == m_half.addr + 32'(m_half.nbytes)) begin
                                dtr_rec_t j;
                                j.addr = m_half.addr;
                                j.nbytes = 3'(int'(m_half.nbytes) + int'(cmp_bytes));
                                j.write = m_half.write;
                                j.data = m_half.data | (cur.data << (8 * int'(m_half.nbytes)));
                                mq.push_back(j);
                            end else begin
                                mq.push_back(m_half);
                                mq.push_back(cur);
                            end
                        end
                    end else if (!cmp_err) begin
                        mq.push_back(cur);
                    end
                    m_held = 1'b0;
                end else begin
                    m_held = 1'b0;
                    if (!cmp_err) mq.push_back(cur);
                end
            end
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit er;
            er = (mq.size() <= DEPTH - 2);
            chk(cmp_ready == er, "cmp_ready R10", 68'(cmp_ready), 68'(er));
            chk(trc_valid == (mq.size() != 0), "trc_valid", 68'(trc_valid), 68'(mq.size() != 0));
            if (trc_valid && mq.size() != 0) begin
                chk({trc_addr, trc_bytes, trc_write, trc_data} == mq[0], "record",
                    {trc_addr, trc_bytes, trc_write, trc_data}, mq[0]);
            end
        end
    end

    always @(negedge clk) begin
        if (rand_rdy) trc_ready = ($urandom % 4) != 0;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic send(input logic [1:0] p, input bit e, input bit w,
                        input logic [31:0] a, input int b, input logic [31:0] d);
        cmp_valid = 1'b1; cmp_part = p; cmp_err = e; cmp_write = w;
        cmp_addr = a; cmp_bytes = 3'(b); cmp_data = d;
        while (!cmp_ready) @(negedge clk);
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cur_req = "R1";
        chk(trc_valid == 1'b0, "reset valid R1", 68'(trc_valid), 68'd0);
        chk(cmp_ready == 1'b1, "reset ready R1", 68'(cmp_ready), 68'd1);

        cur_req = "R2";
        send(2'b00, 0, 0, 32'h0000_1000, 4, 32'hDEAD_BEEF);
        send(2'b00, 0, 1, 32'h0000_2002, 2, 32'hFFFF_1234);
        send(2'b11, 0, 0, 32'h0000_3001, 1, 32'hAABB_CC5A);
        idle(4);

        cur_req = "R11";
        send(2'b00, 0, 1, 32'h0000_0040, 1, 32'hFFFF_FFFF);
        idle(3);

        cur_req = "R3";
        send(2'b00, 1, 0, 32'h0000_4000, 4, 32'h1111_1111);
        send(2'b01, 1, 0, 32'h0000_4001, 3, 32'h0022_2222);
        send(2'b10, 0, 0, 32'h0000_4004, 1, 32'h0000_0033);
        send(2'b01, 0, 1, 32'h0000_4011, 3, 32'h0044_4444);
        send(2'b10, 1, 1, 32'h0000_4014, 1, 32'h0000_0055);
        idle(4);

        cur_req = "R4";
        trace_data_sel = 1'b0;
        send(2'b00, 0, 0, 32'h0000_5000, 4, 32'h5555_5555);
        trace_data_sel = 1'b1;
        send(2'b01, 0, 0, 32'h0000_5003, 1, 32'h0000_0066);
        trace_data_sel = 1'b0;
        send(2'b00, 0, 0, 32'h0000_5100, 4, 32'h7777_7777);
        trace_data_sel = 1'b1;
        idle(3);

        cur_req = "R8";
        send(2'b10, 0, 0, 32'h0000_5004, 1, 32'h0000_0088);
        idle(3);

        cur_req = "R5";
        send(2'b01, 0, 0, 32'h0000_6001, 3, 32'hFFCC_BBAA);
        idle(5);
        cur_req = "R6";
        send(2'b10, 0, 0, 32'h0000_6004, 1, 32'hFFFF_FFDD);
        idle(2);
        send(2'b01, 0, 1, 32'h0000_6103, 1, 32'h0000_0011);
        send(2'b10, 0, 1, 32'h0000_6104, 1, 32'h0000_0022);
        idle(3);

        cur_req = "R5";
        send(2'b01, 0, 0, 32'h0000_6201, 3, 32'h0012_3456);
        send(2'b00, 0, 0, 32'h0000_6300, 4, 32'h9999_9999);
        send(2'b10, 0, 0, 32'h0000_6204, 1, 32'h0000_0077);
        idle(3);

        cur_req = "R7";
        send(2'b01, 0, 0, 32'hFFFF_FFFE, 2, 32'h0000_1122);
        send(2'b10, 0, 0, 32'h0000_0000, 2, 32'h0000_3344);
        idle(4);
        send(2'b01, 0, 1, 32'h0000_7001, 3, 32'h00AB_CDEF);
        send(2'b10, 0, 1, 32'h0000_7100, 1, 32'h0000_0012);
        idle(4);

        cur_req = "R9";
        trc_ready = 1'b0;
        send(2'b00, 0, 0, 32'h0000_8000, 4, 32'h0102_0304);
        idle(4);
        cur_req = "R10";
        send(2'b00, 0, 1, 32'h0000_8004, 4, 32'h0506_0708);
        send(2'b00, 0, 0, 32'h0000_8008, 2, 32'h0000_090A);
        fork
            send(2'b00, 0, 0, 32'h0000_800C, 4, 32'h0B0C_0D0E);
            begin
                idle(4);
                chk(cmp_ready == 1'b0, "stalled ready R10", 68'(cmp_ready), 68'd0);
                trc_ready = 1'b1;
            end
        join
        idle(6);

        cur_req = "R10";
        rand_rdy = 1'b1;
        for (int k = 0; k < 400; k++) begin
            int          kind;
            int          b1;
            logic [31:0] a;
            bit          e1, e2, w;
            kind = $urandom % 5;
            a = $urandom;
            w = $urandom % 2;
            e1 = ($urandom % 8) == 0;
            e2 = ($urandom % 8) == 0;
            trace_data_sel = ($urandom % 10) != 0;
            b1 = 1 + ($urandom % 3);
            case (kind)
                0: send(2'b00, e1, w, a, 1 << ($urandom % 3), $urandom);
                1: begin
                    send(2'b01, e1, w, a, b1, $urandom);
                    send(2'b10, e2, w, a + 32'(b1), 4 - b1, $urandom);
                end
                2: begin
                    send(2'b01, e1, w, 32'h0 - 32'(b1), b1, $urandom);
                    send(2'b10, e2, w, 32'h0, 4 - b1, $urandom);
                end
                3: begin
                    send(2'b01, e1, w, a, b1, $urandom);
                    send(2'b10, e2, w, a + 32'h40, 4 - b1, $urandom);
                end
                default: send(2'b10, e1, w, a, b1, $urandom);
            endcase
        end
        trace_data_sel = 1'b1;
        rand_rdy = 1'b0;
        trc_ready = 1'b1;
        idle(10);
        chk(mq.size() == 0 && !trc_valid, "drained R10", 68'(trc_valid), 68'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule